// File: doc/BRIEF.md
# Zero-Suppressed Digitizer Channel Framer

This block serves one channel of a free-running 10-bit converter that delivers a sample on every clock (40 MHz, so one time bin is 25 ns). Each sample passes through a delay line whose tap is set to match the trigger latency. When a trigger arrives, the sample that the delay line presents is the one taken at the moment of the physical event. The trigger opens an observation window of a programmable number of time bins. Inside that window the block compares every delayed sample with the channel's threshold. Only samples above the threshold go to the output stream.

The output is a stream of 16-bit words, written two lanes at a time into a FIFO-style port. An event starts with two header words. The first carries the module and channel identity and the second carries the buffered event number. Each kept sample then produces an amplitude word and a time-bin word. A single trailer word closes the event and holds the number of kept samples. In every word the top bit is an even-parity check bit and the next three bits give the word type. When the downstream buffer reports full, writes are dropped and a sticky overflow flag is set.

Top module: `zs_channel_framer`

## Requirements
- R1: With L = cfg_latency, clamped to a maximum of 99, time bin i of a window carries the sample that was on sample_in at the clock edge i−L edges after the trigger-accepting edge. With L=0, bin 0 is the sample present at the trigger edge.
- R2: The edge that accepts a trigger writes a pair with wr_en=11. Lane 0 (wr_data[15:0]) is header 1: type 001, bit 11 = 0, bits 10..5 = cfg_module, bits 4..0 = cfg_channel. Lane 1 (wr_data[31:16]) is header 2.
- R3: Header 2 is type 001 with the event number in bits 11..0. The number is 1 for the first event after reset, counts up by one per accepted trigger, and wraps from 5 back to 1.
- R4: The window lasts N bins, processed on the N edges that follow the trigger edge. N is cfg_count, with 0 meaning 1020 and values above 1024 treated as 1024. The trailer is written on the next edge after the last bin.
- R5: A bin is written only when its sample is strictly greater than cfg_threshold. It is written as one pair: lane 0 holds the amplitude word (type 010, bits 9..0 = sample) and lane 1 holds the time word (type 011, bits 9..0 = bin index, counting from 0).
- R6: The trailer is written on lane 0 only (wr_en=01, lane 1 = 0). It is type 100 with bits 9..0 giving the number of pairs actually written in the window, saturating at 1023.
- R7: A trigger is accepted only when no window is open and no trailer is being written. Any other trigger has no effect on the stream.
- R8: Bit 15 of every written word makes the parity of the 16-bit word even.
- R9: When wr_full is high at an edge where a write would happen, nothing is written (wr_en=0, wr_data=0) and overflow becomes 1. A dropped pair does not count toward the trailer. Overflow stays at 1 until reset.
- R10: During and right after reset, wr_en=0, wr_data=0 and overflow=0, and the event number restarts at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_in | input | 10 | Converter sample, one per clock |
| trig | input | 1 | Trigger request |
| cfg_latency | input | 7 | Delay tap, 0..99 (values above are clamped) |
| cfg_count | input | 11 | Window length in bins (0 selects 1020) |
| cfg_threshold | input | 10 | Suppression threshold |
| cfg_module | input | 6 | Module number minus one |
| cfg_channel | input | 5 | Channel number minus one |
| wr_full | input | 1 | Downstream buffer full |
| wr_en | output | 2 | Per-lane write strobes (bit 0 = lane 0) |
| wr_data | output | 32 | Lane 1 in bits 31..16, lane 0 in bits 15..0 |
| overflow | output | 1 | Sticky flag for dropped writes |

## Verification
Some properties are checked by assertions on every cycle:
- no write on an edge that saw wr_full, and overflow never clearing;
- even parity on every written lane, and a time word always following an amplitude word;
- amplitudes written only when above the threshold, and trailers only on lane 0;
- the trailer following the last bin, an ignored trigger leaving the bin count advancing, and the zero-tap delay equal to the previous input.

Other behaviours need a model that remembers history, so only the bench scenarios can show them:
- the exact sample taken for each bin at a given tap, including the clamped tap of 99;
- the default and clamped window lengths;
- the saturating pair count and the event-number wrap.

// File: rtl/zsf_pkg.sv
package zsf_pkg;

   typedef enum logic [2:0] {
      TY_HDR  = 3'b001,
      TY_ADC  = 3'b010,
      TY_TIME = 3'b011,
      TY_TRL  = 3'b100
   } word_type_e;

   // builds a 16-bit word: even-parity bit, type code, 12-bit payload
   function automatic logic [15:0] zsf_word(word_type_e ty, logic [11:0] payload);
      logic [14:0] body;
      body = {ty, payload};
      return {^body, body};
   endfunction

endpackage

// File: rtl/zsf_delay_line.sv
module zsf_delay_line #(
   parameter int W      = 10,
   parameter int STAGES = 100,
   localparam int SEL_W = $clog2(STAGES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     din,
   input  logic [SEL_W-1:0] sel,
   output logic [W-1:0]     dout
);

   logic [W-1:0]     sr [STAGES];
   logic [SEL_W-1:0] sel_c;
   logic             past_ok;

   initial begin : p_param_check
      assert (STAGES >= 2) else $error("STAGES must be at least 2");
   end

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sr[g] <= '0;
               else        sr[g] <= din;
         end else begin : g_body
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sr[g] <= '0;
               else        sr[g] <= sr[g-1];
         end
      end
   endgenerate

   assign sel_c = (sel > SEL_W'(STAGES - 1)) ? SEL_W'(STAGES - 1) : sel;
   assign dout  = sr[sel_c];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;

   AST_TAP0_IS_PREV: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && sel == '0) |-> dout == $past(din)); // R1

endmodule

// File: rtl/zsf_window_ctrl.sv
module zsf_window_ctrl #(
   parameter int MAX_BINS     = 1024,
   parameter int DEFAULT_BINS = 1020,
   parameter int EVENTS       = 5,
   localparam int BIN_W = $clog2(MAX_BINS),
   localparam int LEN_W = $clog2(MAX_BINS + 1),
   localparam int EVT_W = $clog2(EVENTS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig,
   input  logic [LEN_W-1:0] cfg_count,
   output logic             start,
   output logic             in_win,
   output logic             last,
   output logic             trail,
   output logic [BIN_W-1:0] bin,
   output logic [EVT_W-1:0] evt
);

   typedef enum logic [1:0] {S_IDLE, S_WIN, S_TRL} state_e;

   state_e           state;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] len_eff;

   initial begin : p_param_check
      assert (DEFAULT_BINS >= 1 && DEFAULT_BINS <= MAX_BINS) else $error("bad DEFAULT_BINS");
      assert (EVENTS >= 1) else $error("EVENTS must be positive");
   end

   always_comb begin
      if (cfg_count == '0)                   len_eff = LEN_W'(DEFAULT_BINS);
      else if (cfg_count > LEN_W'(MAX_BINS)) len_eff = LEN_W'(MAX_BINS);
      else                                   len_eff = cfg_count;
   end

   assign start  = (state == S_IDLE) && trig;
   assign in_win = (state == S_WIN);
   assign trail  = (state == S_TRL);
   assign last   = in_win && (LEN_W'(bin) == len_q - LEN_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         bin   <= '0;
         len_q <= '0;
         evt   <= EVT_W'(1);
      end else begin
         unique case (state)
            S_IDLE: if (trig) begin
               state <= S_WIN;
               bin   <= '0;
               len_q <= len_eff;
               evt   <= (evt == EVT_W'(EVENTS)) ? EVT_W'(1) : evt + 1'b1;
            end
            S_WIN: begin
               if (last) state <= S_TRL;
               else      bin   <= bin + 1'b1;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   AST_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && trig && !last) |=> (in_win && bin == $past(bin) + 1'b1)); // R7
   AST_TRAIL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> trail); // R4
   AST_TRAIL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      trail |=> (!trail && !in_win)); // R4
   AST_EVT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (evt >= EVT_W'(1) && evt <= EVT_W'(EVENTS))); // R3

endmodule

// File: rtl/zs_channel_framer.sv
module zs_channel_framer #(
   parameter int SAMPLE_W     = 10,
   parameter int MAX_STAGES   = 100,
   parameter int MAX_BINS     = 1024,
   parameter int DEFAULT_BINS = 1020,
   parameter int EVENTS       = 5,
   parameter int CNT_W        = 10,
   localparam int LAT_W = $clog2(MAX_STAGES),
   localparam int BIN_W = $clog2(MAX_BINS),
   localparam int LEN_W = $clog2(MAX_BINS + 1),
   localparam int EVT_W = $clog2(EVENTS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] sample_in,
   input  logic                trig,
   input  logic [LAT_W-1:0]    cfg_latency,
   input  logic [LEN_W-1:0]    cfg_count,
   input  logic [SAMPLE_W-1:0] cfg_threshold,
   input  logic [5:0]          cfg_module,
   input  logic [4:0]          cfg_channel,
   input  logic                wr_full,
   output logic [1:0]          wr_en,
   output logic [31:0]         wr_data,
   output logic                overflow
);
   import zsf_pkg::*;

   logic [SAMPLE_W-1:0] dly;
   logic                start, in_win, last, trail, keep;
   logic [BIN_W-1:0]    bin;
   logic [EVT_W-1:0]    evt;
   logic [CNT_W-1:0]    pairs;
   logic [1:0]          want_en;
   logic [31:0]         want_data;

   initial begin : p_param_check
      assert (SAMPLE_W <= 12 && BIN_W <= 12 && CNT_W <= 12 && EVT_W <= 12)
         else $error("payload fields exceed 12 bits");
   end

   zsf_delay_line #(.W(SAMPLE_W), .STAGES(MAX_STAGES)) u_dly (
      .clk(clk), .rst_n(rst_n), .din(sample_in), .sel(cfg_latency), .dout(dly));

   zsf_window_ctrl #(.MAX_BINS(MAX_BINS), .DEFAULT_BINS(DEFAULT_BINS), .EVENTS(EVENTS)) u_ctl (
      .clk(clk), .rst_n(rst_n), .trig(trig), .cfg_count(cfg_count),
      .start(start), .in_win(in_win), .last(last), .trail(trail), .bin(bin), .evt(evt));

   assign keep = in_win && (dly > cfg_threshold);

   always_comb begin
      want_en   = 2'b00;
      want_data = '0;
      if (start) begin
         want_en   = 2'b11;
         want_data = {zsf_word(TY_HDR, 12'(evt)),
                      zsf_word(TY_HDR, {1'b0, cfg_module, cfg_channel})};
      end else if (keep) begin
         want_en   = 2'b11;
         want_data = {zsf_word(TY_TIME, 12'(bin)), zsf_word(TY_ADC, 12'(dly))};
      end else if (trail) begin
         want_en   = 2'b01;
         want_data = {16'h0000, zsf_word(TY_TRL, 12'(pairs))};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en    <= 2'b00;
         wr_data  <= '0;
         overflow <= 1'b0;
         pairs    <= '0;
      end else begin
         wr_en   <= 2'b00;
         wr_data <= '0;
         if (want_en != 2'b00) begin
            if (wr_full) overflow <= 1'b1;
            else begin
               wr_en   <= want_en;
               wr_data <= want_data;
            end
         end
         if (start)
            pairs <= '0;
         else if (keep && !wr_full && pairs != {CNT_W{1'b1}})
            pairs <= pairs + 1'b1;
      end
   end

   AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      wr_full |=> wr_en == 2'b00); // R9
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow); // R9
   AST_EVEN_PARITY_L0: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[0] |-> !(^wr_data[15:0])); // R8
   AST_EVEN_PARITY_L1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[1] |-> !(^wr_data[31:16])); // R8
   AST_TIME_AFTER_ADC: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en == 2'b11 && wr_data[14:12] == TY_ADC) |-> wr_data[30:28] == TY_TIME); // R5
   AST_ABOVE_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en == 2'b11 && wr_data[14:12] == TY_ADC)
         |-> wr_data[SAMPLE_W-1:0] > $past(cfg_threshold)); // R5
   AST_TRAILER_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en == 2'b01) |-> (wr_data[14:12] == TY_TRL && wr_data[31:16] == 16'h0000)); // R6

endmodule

// File: tb/sim_zs_channel_framer.sv
module sim_zs_channel_framer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  sample_in = '0;
   logic        trig = 1'b0;
   logic [6:0]  cfg_latency = '0;
   logic [10:0] cfg_count = '0;
   logic [9:0]  cfg_threshold = '0;
   logic [5:0]  cfg_module = '0;
   logic [4:0]  cfg_channel = '0;
   logic        wr_full = 1'b0;
   logic [1:0]  wr_en;
   logic [31:0] wr_data;
   logic        overflow;

   int    checks = 0;
   int    errors = 0;
   int    cyc = 0;
   string cur_req = "R10";

   zs_channel_framer u0 (
      .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .trig(trig),
      .cfg_latency(cfg_latency), .cfg_count(cfg_count), .cfg_threshold(cfg_threshold),
      .cfg_module(cfg_module), .cfg_channel(cfg_channel), .wr_full(wr_full),
      .wr_en(wr_en), .wr_data(wr_data), .overflow(overflow));

   always #5 clk = ~clk;

   // ---------------- behavioural reference model ----------------
   int          hist [128];
   int          m_st, m_bin, m_n, m_pairs, m_evt, lat, d;
   logic        m_ovf;
   logic [1:0]  e_en;
   logic [31:0] e_dat;

   function automatic logic [15:0] mk(input int ty, input int pay);
      logic [14:0] b;
      b = {ty[2:0], pay[11:0]};
      return {^b, b};
   endfunction

   task automatic put(input logic [1:0] en, input logic [31:0] dat, input bit is_pair);
      if (wr_full) m_ovf = 1'b1;
      else begin
         e_en  = en;
         e_dat = dat;
         if (is_pair && m_pairs < 1023) m_pairs++;
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_bin = 0; m_n = 0; m_pairs = 0; m_evt = 1;
         m_ovf = 1'b0; e_en = 2'b00; e_dat = '0;
         for (int j = 0; j < 128; j++) hist[j] = 0;
      end else begin
         lat = (int'(cfg_latency) > 99) ? 99 : int'(cfg_latency);
         d = hist[lat];
         e_en = 2'b00; e_dat = '0;
         case (m_st)
            0: if (trig) begin
               m_n = (cfg_count == 0) ? 1020 : ((int'(cfg_count) > 1024) ? 1024 : int'(cfg_count));
               m_bin = 0; m_pairs = 0; m_st = 1;
               put(2'b11, {mk(1, m_evt), mk(1, {20'd0, 1'b0, cfg_module, cfg_channel})}, 1'b0);
               m_evt = (m_evt == 5) ? 1 : m_evt + 1;
            end
            1: begin
               if (d > int'(cfg_threshold)) put(2'b11, {mk(3, m_bin), mk(2, d)}, 1'b1);
               if (m_bin == m_n - 1) m_st = 2;
               else m_bin++;
            end
            default: begin
               put(2'b01, {16'h0000, mk(4, m_pairs)}, 1'b0);
               m_st = 0;
            end
         endcase
         for (int j = 127; j > 0; j--) hist[j] = hist[j-1];
         hist[0] = int'(sample_in);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic compare();
      checks++;
      if (wr_en !== e_en || wr_data !== e_dat || overflow !== m_ovf) begin
         errors++;
         $display("FAIL %s cycle %0d: wr_en=%b wr_data=%h overflow=%b expected %b %h %b",
                  cur_req, cyc, wr_en, wr_data, overflow, e_en, e_dat, m_ovf);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      compare();
      cyc++;
      sample_in = 10'(((cyc * 37 + cyc / 7) % 1023) + 1);
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic fire();
      trig = 1'b1;
      tick();
      trig = 1'b0;
   endtask

   initial begin
      cfg_module = 6'd42; cfg_channel = 5'd17;
      cur_req = "R10";
      run(4);
      rst_n = 1'b1;
      run(3);

      // R1 R2 R3 R5 R8: short window, tap 3, mid threshold
      cur_req = "R1";
      cfg_latency = 7'd3; cfg_threshold = 10'd600; cfg_count = 11'd40;
      run(10); fire(); run(50);

      // R1: tap clamped from 127 to 99
      cur_req = "R1";
      cfg_latency = 7'd127; cfg_threshold = 10'd300; cfg_count = 11'd30;
      run(110); fire(); run(40);

      // R7: triggers inside window and on the trailer edge are ignored
      cur_req = "R7";
      cfg_latency = 7'd0; cfg_threshold = 10'd200; cfg_count = 11'd10;
      fire(); run(4); fire(); run(4);
      fire(); fire(); run(5);

      // R4: count 0 selects 1020 bins
      cur_req = "R4";
      cfg_threshold = 10'd1000; cfg_count = 11'd0;
      fire(); run(1030);

      // R6: count 2000 clamps to 1024, all bins kept, trailer saturates at 1023
      cur_req = "R6";
      cfg_threshold = 10'd0; cfg_count = 11'd2000;
      fire(); run(1030);

      // R9: full during header and mid window, dropped pairs not counted
      cur_req = "R9";
      cfg_threshold = 10'd100; cfg_count = 11'd20;
      wr_full = 1'b1; fire(); wr_full = 1'b0;
      run(5); wr_full = 1'b1; run(3); wr_full = 1'b0; run(20);
      checks++;
      if (overflow !== 1'b1) begin
         errors++;
         $display("FAIL R9: overflow=%b expected 1", overflow);
      end

      // R3: back-to-back events exercise the event number wrap
      cur_req = "R3";
      cfg_count = 11'd3; cfg_threshold = 10'd500;
      for (int e = 0; e < 7; e++) begin
         fire(); run(5);
      end

      // R10: reset clears outputs and event number
      cur_req = "R10";
      rst_n = 1'b0; run(2);
      checks++;
      if (wr_en !== 2'b00 || overflow !== 1'b0) begin
         errors++;
         $display("FAIL R10: wr_en=%b overflow=%b expected 00 0", wr_en, overflow);
      end
      rst_n = 1'b1; run(2);
      cur_req = "R2";
      fire(); run(8);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule